// File: doc/BRIEF.md
# SMBus Slave Read-Transfer Controller

This block is the target side of an SMBus/I2C read transaction. It watches the SCL and SDA lines, which it samples into the system clock domain, and finds START and STOP conditions. After a START it shifts in a 7-bit address and the direction bit. For a read it decides whether to claim the transfer and then serialises data bytes from a host-written holding register. SDA is modelled as an open-drain pull-low enable.

The decision to claim an address comes from one of two sources. In automatic mode, the received address is compared with a programmed address under a per-bit care mask. In manual mode, the host sees an interrupt and an acknowledge request, reads the captured address, and posts an accept or reject before SCL falls at the end of the direction bit. Once claimed, each byte is loaded from the holding register at the start of its slot. If the host supplied no fresh byte, the block drops back to a passive receiver state. If the host writes the holding register after the master has refused a byte, while that interrupt is still pending, an error flag is raised.

Events are reported through an interrupt flag, which the host clears with a pulse, and a 4-bit status word.

Top module: `smb_slv_rd`

## Requirements
- R1: After reset, irq_o, ack_req_o and err_o are 0, status_o is 4'b0000 and sda_pull_o is 0 (SDA released).
- R2: With hw_ack_en_i=0, a read address (8th bit = 1) sets irq_o and ack_req_o while SCL is high in the 8th bit, and rx_addr_o shows the 7 received address bits. A one-cycle ack_wr_i pulse clears ack_req_o. ack_val_i=1 makes the block pull SDA low in the 9th bit, and ack_val_i=0 leaves SDA released.
- R3: With hw_ack_en_i=1, the block acknowledges a read address exactly when ((addr ^ own_addr_i) & addr_mask_i) == 0. A mask bit of 1 means the bit must match, and bit 0 means it is ignored. No interrupt is raised during the address bits. irq_o is set once SCL is high in the acknowledge bit.
- R4: An address byte whose direction bit is 0, or a START seen while slv_inhibit_i=1, is never acknowledged and raises no interrupt.
- R5: After an address is not acknowledged, irq_o stays 0 for any further bus clocking until the next START.
- R6: After an acknowledged address, the byte in the holding register is sent MSB first. A 0 bit is a pull-low and a 1 bit is a release. SDA is released during the master's acknowledge bit, and irq_o is set when that bit is sampled. sda_pull_o changes only while the sampled SCL is low.
- R7: If the master acknowledges and the host wrote the holding register after the previous byte was loaded, the new byte is sent next. If the host did not write it, the block stops driving SDA and status_o bit 2 returns to 0.
- R8: A holding-register write while irq_o=1, after the master answered the last byte with NACK, and before STOP or START, sets err_o. A write after irq_o was cleared does not set it. irq_clr_i clears irq_o and err_o.
- R9: status_o = {MASTER, TXMODE, STA, STO} at bits 3..0. MASTER is 0. TXMODE is 1 from the first data byte until STOP, START or the fall-back to receiver. STA is set by a START accepted while not inhibited. STO is set by a STOP while the block is not idle. STA and STO are cleared by irq_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| slv_inhibit_i | input | 1 | Ignore transfers starting while high |
| hw_ack_en_i | input | 1 | 1: automatic address match, 0: host decides |
| own_addr_i | input | AW | Programmed slave address |
| addr_mask_i | input | AW | Care mask for the address compare |
| dat_wr_i | input | 1 | Holding-register write strobe |
| dat_i | input | DW | Byte to transmit |
| ack_wr_i | input | 1 | Host address decision strobe |
| ack_val_i | input | 1 | Host decision: 1 accept, 0 reject |
| irq_clr_i | input | 1 | Clear interrupt, error, STA and STO |
| irq_o | output | 1 | Interrupt flag |
| ack_req_o | output | 1 | Host address decision pending |
| err_o | output | 1 | Write-after-NACK error |
| status_o | output | 4 | {MASTER, TXMODE, STA, STO} |
| rx_addr_o | output | AW | Last captured read address |

## Verification
The bench builds the block with its defaults: a 7-bit address, 8-bit data and a two-stage line synchroniser. The bench holds each SCL phase for 20 system clocks. Detection latency is therefore well inside every phase, so the manual decision window while SCL is high, and the host write between byte slots, can both be hit at known cycles. With a 7-bit mask, the vectors cover all-care, none-care and single-don't-care compares, including matches that differ only in masked bits.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADEC,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_TNACK,
    ST_RXHOLD,
    ST_IGNORE
  } slv_state_e;

  localparam int STAT_W    = 4;
  localparam int SB_MASTER = 3;
  localparam int SB_TXMODE = 2;
  localparam int SB_STA    = 1;
  localparam int SB_STO    = 0;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic sync_o,
  output logic prev_o
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] own_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o
);

  logic [AW-1:0] bit_ok;

  for (genvar g = 0; g < AW; g++) begin : g_bit
    assign bit_ok[g] = ~mask_i[g] | (addr_i[g] ~^ own_i[g]);
  end

  assign hit_o = &bit_ok;

endmodule

// File: rtl/smb_byte_shifter.sv
module smb_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          shift_i,
  input  logic          ser_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_n;

  always_comb begin
    q_n = q_o;
    if (load_i)       q_n = load_val_i;
    else if (shift_i) q_n = {q_o[DW-2:0], ser_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_n;
  end

endmodule

// File: rtl/smb_slv_rd.sv
module smb_slv_rd
  import smb_slv_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              slv_inhibit_i,
  input  logic              hw_ack_en_i,
  input  logic [AW-1:0]     own_addr_i,
  input  logic [AW-1:0]     addr_mask_i,
  input  logic              dat_wr_i,
  input  logic [DW-1:0]     dat_i,
  input  logic              ack_wr_i,
  input  logic              ack_val_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              ack_req_o,
  output logic              err_o,
  output logic [STAT_W-1:0] status_o,
  output logic [AW-1:0]     rx_addr_o
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line sampling
  logic [1:0] raw_lines, sync_lines, prev_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .line_i (raw_lines[g]),
      .sync_o (sync_lines[g]),
      .prev_o (prev_lines[g])
    );
  end

  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_s    = sync_lines[0];
  assign scl_p    = prev_lines[0];
  assign sda_s    = sync_lines[1];
  assign sda_p    = prev_lines[1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  // state
  slv_state_e    state_q, state_n;
  logic [CW-1:0] bcnt_q, bcnt_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] dat_q, dat_n;
  logic          dat_full_q, dat_full_n;
  logic          sw_dec_q, sw_dec_n;
  logic          ack_req_q, ack_req_n;
  logic          ackbit_q, ackbit_n;
  logic          nack_q, nack_n;
  logic          irq_q, irq_n, err_q, err_n, sta_q, sta_n, sto_q, sto_n;
  logic          irq_set, sta_set, sto_set, err_set;
  logic          sh_load, sh_shift, sh_ser;
  logic [DW-1:0] sh_q;
  logic          addr_hit, txmode;

  smb_addr_match #(.AW(AW)) u_match (
    .addr_i (addr_q),
    .own_i  (own_addr_i),
    .mask_i (addr_mask_i),
    .hit_o  (addr_hit)
  );

  smb_byte_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (sh_load),
    .load_val_i (dat_q),
    .shift_i    (sh_shift),
    .ser_i      (sh_ser),
    .q_o        (sh_q)
  );

  assign txmode = (state_q == ST_TX) || (state_q == ST_TACK) || (state_q == ST_TNACK);

  always_comb begin
    state_n    = state_q;
    bcnt_n     = bcnt_q;
    addr_n     = addr_q;
    dat_n      = dat_q;
    dat_full_n = dat_full_q;
    sw_dec_n   = sw_dec_q;
    ack_req_n  = ack_req_q;
    ackbit_n   = ackbit_q;
    nack_n     = nack_q;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    sh_ser     = sda_s;
    irq_set    = 1'b0;
    sta_set    = 1'b0;
    sto_set    = 1'b0;

    case (state_q)
      ST_ADDR: begin
        if (scl_rise) begin
          sh_shift = 1'b1;
          if (bcnt_q == LAST_BIT) begin
            bcnt_n = '0;
            if (sda_s) begin
              state_n  = ST_ADEC;
              addr_n   = sh_q[AW-1:0];
              sw_dec_n = 1'b0;
              if (!hw_ack_en_i) begin
                irq_set   = 1'b1;
                ack_req_n = 1'b1;
              end
            end else begin
              state_n = ST_IGNORE;
            end
          end else begin
            bcnt_n = bcnt_q + CW'(1);
          end
        end
      end
      ST_ADEC: begin
        if (ack_wr_i && ack_req_q) begin
          sw_dec_n  = ack_val_i;
          ack_req_n = 1'b0;
        end
        if (scl_fall) begin
          ack_req_n = 1'b0;
          if (hw_ack_en_i ? addr_hit : sw_dec_q) state_n = ST_AACK;
          else                                    state_n = ST_IGNORE;
        end
      end
      ST_AACK: begin
        if (scl_rise && hw_ack_en_i) irq_set = 1'b1;
        if (scl_fall) begin
          bcnt_n = '0;
          if (dat_full_q) begin
            sh_load = 1'b1;
            state_n = ST_TX;
          end else begin
            state_n = ST_RXHOLD;
          end
        end
      end
      ST_TX: begin
        sh_ser = 1'b0;
        if (scl_fall) begin
          if (bcnt_q == LAST_BIT) begin
            bcnt_n  = '0;
            state_n = ST_TACK;
          end else begin
            sh_shift = 1'b1;
            bcnt_n   = bcnt_q + CW'(1);
          end
        end
      end
      ST_TACK: begin
        if (scl_rise) begin
          ackbit_n = ~sda_s;
          nack_n   = sda_s;
          irq_set  = 1'b1;
        end
        if (scl_fall) begin
          if (ackbit_q && dat_full_q) begin
            sh_load = 1'b1;
            state_n = ST_TX;
          end else if (ackbit_q) begin
            state_n = ST_RXHOLD;
          end else begin
            state_n = ST_TNACK;
          end
        end
      end
      default: ;
    endcase

    if (sh_load) dat_full_n = 1'b0;
    if (dat_wr_i) begin
      dat_n      = dat_i;
      dat_full_n = 1'b1;
    end

    if (start_ev) begin
      state_n   = slv_inhibit_i ? ST_IGNORE : ST_ADDR;
      bcnt_n    = '0;
      nack_n    = 1'b0;
      ack_req_n = 1'b0;
      sta_set   = ~slv_inhibit_i;
    end else if (stop_ev) begin
      state_n   = ST_IDLE;
      nack_n    = 1'b0;
      ack_req_n = 1'b0;
      sto_set   = (state_q != ST_IDLE);
    end
  end

  always_comb begin
    err_set = dat_wr_i & nack_q & irq_q & txmode;
    irq_n   = irq_set | (irq_q & ~irq_clr_i);
    err_n   = err_set | (err_q & ~irq_clr_i);
    sta_n   = sta_set | (sta_q & ~irq_clr_i);
    sto_n   = sto_set | (sto_q & ~irq_clr_i);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      bcnt_q     <= '0;
      addr_q     <= '0;
      dat_q      <= '0;
      dat_full_q <= 1'b0;
      sw_dec_q   <= 1'b0;
      ack_req_q  <= 1'b0;
      ackbit_q   <= 1'b0;
      nack_q     <= 1'b0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      sta_q      <= 1'b0;
      sto_q      <= 1'b0;
    end else begin
      state_q    <= state_n;
      bcnt_q     <= bcnt_n;
      addr_q     <= addr_n;
      dat_q      <= dat_n;
      dat_full_q <= dat_full_n;
      sw_dec_q   <= sw_dec_n;
      ack_req_q  <= ack_req_n;
      ackbit_q   <= ackbit_n;
      nack_q     <= nack_n;
      irq_q      <= irq_n;
      err_q      <= err_n;
      sta_q      <= sta_n;
      sto_q      <= sto_n;
    end
  end

  assign sda_pull_o = (state_q == ST_AACK) || ((state_q == ST_TX) && !sh_q[DW-1]);
  assign irq_o      = irq_q;
  assign ack_req_o  = ack_req_q;
  assign err_o      = err_q;
  assign rx_addr_o  = addr_q;
  assign status_o   = {1'b0, txmode, sta_q, sto_q};

  AST_REQ_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ack_req_q) |-> $rose(irq_q)); // R2
  AST_REQ_MANUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ack_req_q) |-> !$past(hw_ack_en_i)); // R3
  AST_IGNORE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_IGNORE) |=> !$rose(irq_q)); // R5
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sda_pull_o) |-> !scl_s); // R6
  AST_ERR_IN_TX: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(err_q) |-> status_o[SB_TXMODE]); // R8
  AST_STOP_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_ev |=> !status_o[SB_TXMODE]); // R9

endmodule

// File: tb/smb_slv_rd_bench.sv
module smb_slv_rd_bench;

  localparam int AW = 7;
  localparam int DW = 8;
  localparam int H  = 20;
  localparam int NV = 8;

  // {addr[30:24], rw[23], own[22:16], mask[15:9], data[8:1], exp_ack[0]}
  localparam logic [30:0] VEC [NV] = '{
    {7'h42, 1'b1, 7'h42, 7'h7F, 8'hA5, 1'b1},
    {7'h43, 1'b1, 7'h42, 7'h7F, 8'h00, 1'b0},
    {7'h43, 1'b1, 7'h42, 7'h7E, 8'h3C, 1'b1},
    {7'h10, 1'b1, 7'h7F, 7'h00, 8'hFF, 1'b1},
    {7'h55, 1'b0, 7'h55, 7'h7F, 8'h00, 1'b0},
    {7'h00, 1'b1, 7'h00, 7'h7F, 8'h00, 1'b1},
    {7'h2A, 1'b1, 7'h6A, 7'h3F, 8'h81, 1'b1},
    {7'h2A, 1'b1, 7'h6A, 7'h40, 8'h00, 1'b0}
  };

  logic clk;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_pull, sda_bus;
  logic inhibit, hw_ack;
  logic [AW-1:0] own_addr, addr_mask, rx_addr;
  logic dat_wr, ack_wr, ack_val, irq_clr;
  logic [DW-1:0] dat;
  logic irq, ack_req, err;
  logic [3:0] status;

  int  n_chk = 0;
  int  n_fail = 0;
  logic done = 1'b0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;

  smb_slv_rd #(.AW(AW), .DW(DW), .SYNC_STAGES(2)) u_smb_slv_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_bus),
    .sda_pull_o    (sda_pull),
    .slv_inhibit_i (inhibit),
    .hw_ack_en_i   (hw_ack),
    .own_addr_i    (own_addr),
    .addr_mask_i   (addr_mask),
    .dat_wr_i      (dat_wr),
    .dat_i         (dat),
    .ack_wr_i      (ack_wr),
    .ack_val_i     (ack_val),
    .irq_clr_i     (irq_clr),
    .irq_o         (irq),
    .ack_req_o     (ack_req),
    .err_o         (err),
    .status_o      (status),
    .rx_addr_o     (rx_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2); b = sda_bus; wt(H/2); m_scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      v[i] = x;
    end
  endtask

  task automatic host_write(input logic [DW-1:0] v);
    dat = v; dat_wr = 1'b1; wt(1); dat_wr = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; wt(1); irq_clr = 1'b0;
  endtask

  task automatic addr_sw(input logic [AW-1:0] a, input logic dec);
    for (int i = AW-1; i >= 0; i--) send_bit(a[i]);
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
    chk("R2 irq on read address", irq, 1);
    chk("R2 ack request raised", ack_req, 1);
    chk("R2 captured address", rx_addr, a);
    ack_val = dec; ack_wr = 1'b1; wt(1); ack_wr = 1'b0;
    chk("R2 ack request cleared by decision", ack_req, 0);
    wt(H/2 - 1); m_scl = 1'b0; wt(H);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] d;
    logic [30:0] v;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    inhibit = 1'b0; hw_ack = 1'b1; own_addr = '0; addr_mask = '1;
    dat_wr = 1'b0; dat = '0; ack_wr = 1'b0; ack_val = 1'b0; irq_clr = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk("R1 irq after reset", irq, 0);
    chk("R1 ack_req after reset", ack_req, 0);
    chk("R1 err after reset", err, 0);
    chk("R1 status after reset", status, 0);
    chk("R1 sda released after reset", sda_pull, 0);

    // automatic address match vectors
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      hw_ack = 1'b1; own_addr = v[22:16]; addr_mask = v[15:9];
      if (v[0]) host_write(v[8:1]);
      bus_start();
      send_byte({v[30:24], v[23]});
      recv_bit(b);
      chk("R3 R4 address acknowledge", !b, v[0]);
      if (v[0]) begin
        chk("R3 irq after ack cycle", irq, 1);
        chk("R9 txmode in first byte", status[2], 1);
        clr_irq();
        recv_byte(d);
        chk("R6 transmitted byte", d, v[8:1]);
        send_bit(1'b1);
        chk("R6 irq at master ack bit", irq, 1);
        clr_irq();
        bus_stop();
        chk("R9 stop ends txmode", status[2], 0);
        chk("R9 sto set by stop", status[0], 1);
      end else begin
        chk("R4 R5 no irq on unclaimed address", irq, 0);
        recv_byte(d);
        send_bit(1'b1);
        chk("R5 irq suppressed until start", irq, 0);
        bus_stop();
      end
      clr_irq();
    end

    // manual accept, then fall back to receiver
    hw_ack = 1'b0;
    host_write(8'h96);
    bus_start();
    addr_sw(7'h31, 1'b1);
    recv_bit(b);
    chk("R2 manual accept drives ack", b, 0);
    clr_irq();
    recv_byte(d);
    chk("R6 byte after manual accept", d, 8'h96);
    send_bit(1'b0);
    chk("R6 irq at master ack bit manual mode", irq, 1);
    chk("R7 fall back clears txmode", status[2], 0);
    chk("R7 fall back releases sda", sda_pull, 0);
    recv_bit(b);
    chk("R7 bus idle high after fall back", b, 1);
    bus_stop();
    clr_irq();

    // two bytes, NACK, write-after-NACK error
    hw_ack = 1'b1; own_addr = 7'h22; addr_mask = 7'h7F;
    host_write(8'h5A);
    bus_start();
    chk("R9 sta set by start", status[1], 1);
    send_byte({7'h22, 1'b1});
    recv_bit(b);
    chk("R3 exact match ack", b, 0);
    clr_irq();
    host_write(8'hC3);
    recv_byte(d);
    chk("R6 first byte", d, 8'h5A);
    send_bit(1'b0);
    chk("R6 irq after first byte", irq, 1);
    clr_irq();
    recv_byte(d);
    chk("R7 second byte from fresh write", d, 8'hC3);
    send_bit(1'b1);
    chk("R6 irq after nacked byte", irq, 1);
    chk("R9 txmode held after nack", status[2], 1);
    chk("R8 no error before write", err, 0);
    host_write(8'h11);
    chk("R8 error on write after nack", err, 1);
    clr_irq();
    chk("R8 error cleared with irq", err, 0);
    host_write(8'h22);
    chk("R8 no error once irq cleared", err, 0);
    bus_stop();
    chk("R9 stop ends txmode", status[2], 0);
    chk("R9 sto after stop", status[0], 1);
    chk("R9 master bit zero", status[3], 0);
    clr_irq();
    chk("R9 sta sto cleared", status, 0);

    // manual reject suppresses interrupts
    hw_ack = 1'b0;
    bus_start();
    addr_sw(7'h31, 1'b0);
    recv_bit(b);
    chk("R2 manual reject leaves sda high", b, 1);
    clr_irq();
    recv_byte(d);
    send_bit(1'b1);
    chk("R5 irq suppressed after reject", irq, 0);
    bus_stop();
    clr_irq();

    // inhibited start
    hw_ack = 1'b1; own_addr = 7'h22; addr_mask = 7'h7F; inhibit = 1'b1;
    bus_start();
    send_byte({7'h22, 1'b1});
    recv_bit(b);
    chk("R4 inhibit blocks ack", b, 1);
    chk("R4 inhibit blocks irq", irq, 0);
    bus_stop();
    inhibit = 1'b0;
    clr_irq();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule